// File: doc/BRIEF.md
# Paired In-Order Issue Stage

This block is the issue stage of a two-wide in-order pipeline. The decoder hands it a pair of decoded instructions on a valid/ready handshake. The block keeps them in two holding slots: slot 0 holds the older instruction and slot 1 the younger. Each cycle it decides which held instructions go to the two execution pipes. Pipe 0 always takes the older instruction. Pipe 1 can take the younger one only when the older one issues in the same cycle.

A per-register countdown scoreboard records the results that have not yet been written back. An instruction is held while any source it enables names a register whose result is still pending, which blocks read-after-write hazards. When the younger instruction cannot issue, it moves into slot 0 on the next clock edge. It can be blocked by a pending source, by reading its partner's destination, or by being a multiply, since multiplies are restricted to pipe 0. A flush empties both slots and clears every pending mark. Back-pressure is simple. `in_ready` is high only when both slots will be empty after the current cycle, and a pair transfers on an edge where `in_valid` and `in_ready` are both high. The decoder must hold its pair stable until that edge.

Top module: `pair_issue_stage`

## Requirements
- R1: `in_ready` is high exactly when flush is low and every occupied slot issues in the current cycle. A pair transfers on a rising edge where `in_valid` and `in_ready` are both high, and while `in_ready` is low the offered pair is not taken.
- R2: Pipe 0 carries the older held instruction. `p1_issue` is never high unless `p0_issue` is high, and two independent ALU instructions of one pair issue together in the first cycle after the edge that transferred them.
- R3: When the slot-0 instruction is blocked, the slot-1 instruction does not issue. Once slot 0 is free of hazards, both issue together in the same cycle.
- R4: An instruction issued in cycle c with latency L (3 bits; a value of 1 to 7, with 0 treated as 1) blocks every instruction that reads its destination. Cycle c+L is the first cycle in which such a reader may issue.
- R5: Source field k occupies bits [4k+3:4k] of the 12-bit source bus. If any enabled source field of slot 1 names the non-zero destination of the slot-0 instruction, only slot 0 issues. The younger instruction then issues from pipe 0 no earlier than L cycles later, where L is the latency of the slot-0 instruction.
- R6: A multiply (mul bit = 1) never issues on pipe 1. A multiply held in slot 1 moves to slot 0 and issues on pipe 0 in the following cycle if it has no other hazard.
- R7: Issuing to register 0, or with the destination-enable bit low, creates no pending mark, so a reader of that index is not delayed.
- R8: During a cycle with flush high, both issue strobes and `in_ready` are low. At the next edge both held instructions are discarded and never issue, and every pending mark is cleared.
- R9: A pair offered with slot-0 valid low and slot-1 valid high places the slot-1 instruction into slot 0, and it issues on pipe 0.
- R10: A source field whose enable bit is low is never checked against pending marks or against the partner's destination.
- R11: After reset no instruction is held, both issue strobes are low, `in_ready` is high and no register is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Discards held instructions and clears pending marks |
| in_valid | input | 1 | Decoder offers a pair |
| in_ready | output | 1 | Stage takes the offered pair at this edge |
| s0_valid | input | 1 | Older offered instruction present |
| s0_mul | input | 1 | Older instruction is a multiply |
| s0_lat | input | 3 | Older instruction result latency |
| s0_dst_en | input | 1 | Older instruction writes a register |
| s0_dst | input | 4 | Older destination index |
| s0_src_en | input | 3 | Older source field enables |
| s0_src | input | 12 | Older source indices, field k at [4k+3:4k] |
| s1_valid | input | 1 | Younger offered instruction present |
| s1_mul | input | 1 | Younger instruction is a multiply |
| s1_lat | input | 3 | Younger instruction result latency |
| s1_dst_en | input | 1 | Younger instruction writes a register |
| s1_dst | input | 4 | Younger destination index |
| s1_src_en | input | 3 | Younger source field enables |
| s1_src | input | 12 | Younger source indices |
| p0_issue | output | 1 | Pipe 0 issue strobe |
| p0_mul | output | 1 | Pipe 0 instruction is a multiply |
| p0_dst_en | output | 1 | Pipe 0 instruction writes a register |
| p0_dst | output | 4 | Pipe 0 destination index |
| p0_lat | output | 3 | Pipe 0 latency |
| p1_issue | output | 1 | Pipe 1 issue strobe |
| p1_dst_en | output | 1 | Pipe 1 instruction writes a register |
| p1_dst | output | 4 | Pipe 1 destination index |
| p1_lat | output | 3 | Pipe 1 latency |

## Verification
A pair taken at an edge is offered to the pipes during the very next cycle, and its issue strobes are combinational from the held slots. A reader of a pending register issues exactly L cycles after its producer. The bench therefore stamps every strobe with a cycle number, sampling a quarter period after each falling edge, and checks the differences between stamps for the latency, pairing and moved-instruction cases. Flush and `in_ready` are checked inside the cycle in which they act, and discarded instructions are checked afterwards by counting the strobes that carry their destinations.

// File: rtl/issue_pkg.sv
package issue_pkg;
  parameter int unsigned REG_W = 4;
  parameter int unsigned NSRC  = 3;
  parameter int unsigned LAT_W = 3;
  localparam int unsigned NREG  = 1 << REG_W;
  localparam int unsigned SRC_W = NSRC * REG_W;

  typedef struct packed {
    logic             vld;
    logic             mul;
    logic [LAT_W-1:0] lat;
    logic             dst_en;
    logic [REG_W-1:0] dst;
    logic [NSRC-1:0]  src_en;
    logic [SRC_W-1:0] src;
  } instr_t;
endpackage

// File: rtl/issue_scoreboard.sv
module issue_scoreboard
  import issue_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             wr0_en,
  input  logic [REG_W-1:0] wr0_idx,
  input  logic [LAT_W-1:0] wr0_lat,
  input  logic             wr1_en,
  input  logic [REG_W-1:0] wr1_idx,
  input  logic [LAT_W-1:0] wr1_lat,
  output logic [NREG-1:0]  busy
);
  // preload is latency-1 so a latency of one frees the register next cycle
  function automatic logic [LAT_W-1:0] preload(input logic [LAT_W-1:0] lat);
    return (lat == '0) ? '0 : lat - 1'b1;
  endfunction

  assign busy[0] = 1'b0;

  for (genvar r = 1; r < NREG; r++) begin : g_reg
    logic [LAT_W-1:0] cnt_q;
    logic             hit0, hit1;
    assign hit0 = wr0_en && (wr0_idx == REG_W'(r));
    assign hit1 = wr1_en && (wr1_idx == REG_W'(r));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (flush)         cnt_q <= '0;
      else if (hit1)          cnt_q <= preload(wr1_lat);
      else if (hit0)          cnt_q <= preload(wr0_lat);
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign busy[r] = (cnt_q != '0);
  end
endmodule

// File: rtl/issue_hazard.sv
module issue_hazard
  import issue_pkg::*;
(
  input  instr_t           ins,
  input  logic [NREG-1:0]  busy,
  input  logic             older_wr,
  input  logic [REG_W-1:0] older_dst,
  output logic             clear
);
  always_comb begin
    logic [REG_W-1:0] idx;
    idx   = '0;
    clear = 1'b1;
    for (int k = 0; k < NSRC; k++) begin
      idx = ins.src[k*REG_W +: REG_W];
      if (ins.src_en[k]) begin
        if (busy[idx]) clear = 1'b0;
        if (older_wr && (idx == older_dst) && (idx != '0)) clear = 1'b0;
      end
    end
  end
endmodule

// File: rtl/issue_slots.sv
module issue_slots
  import issue_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   flush,
  input  logic   take,
  input  instr_t in0,
  input  instr_t in1,
  input  logic   iss0,
  input  logic   iss1,
  output instr_t slot0,
  output instr_t slot1
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot0 <= '0;
      slot1 <= '0;
    end else if (flush) begin
      slot0 <= '0;
      slot1 <= '0;
    end else if (take) begin
      if (in0.vld) begin
        slot0 <= in0;
        slot1 <= in1;
      end else begin
        slot0 <= in1;
        slot1 <= '0;
      end
    end else if (iss0) begin
      slot0 <= iss1 ? '0 : slot1;
      slot1 <= '0;
    end
  end
endmodule

// File: rtl/pair_issue_stage.sv
module pair_issue_stage
  import issue_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             s0_valid,
  input  logic             s0_mul,
  input  logic [LAT_W-1:0] s0_lat,
  input  logic             s0_dst_en,
  input  logic [REG_W-1:0] s0_dst,
  input  logic [NSRC-1:0]  s0_src_en,
  input  logic [SRC_W-1:0] s0_src,
  input  logic             s1_valid,
  input  logic             s1_mul,
  input  logic [LAT_W-1:0] s1_lat,
  input  logic             s1_dst_en,
  input  logic [REG_W-1:0] s1_dst,
  input  logic [NSRC-1:0]  s1_src_en,
  input  logic [SRC_W-1:0] s1_src,
  output logic             p0_issue,
  output logic             p0_mul,
  output logic             p0_dst_en,
  output logic [REG_W-1:0] p0_dst,
  output logic [LAT_W-1:0] p0_lat,
  output logic             p1_issue,
  output logic             p1_dst_en,
  output logic [REG_W-1:0] p1_dst,
  output logic [LAT_W-1:0] p1_lat
);
  instr_t          in_pair [2];
  instr_t          slot    [2];
  logic [1:0]      clear;
  logic [1:0]      iss;
  logic [NREG-1:0] busy_vec;
  logic            take;

  assign in_pair[0] = '{vld: s0_valid, mul: s0_mul, lat: s0_lat, dst_en: s0_dst_en,
                        dst: s0_dst, src_en: s0_src_en, src: s0_src};
  assign in_pair[1] = '{vld: s1_valid, mul: s1_mul, lat: s1_lat, dst_en: s1_dst_en,
                        dst: s1_dst, src_en: s1_src_en, src: s1_src};

  issue_slots u_slots (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush),
    .take  (take),
    .in0   (in_pair[0]),
    .in1   (in_pair[1]),
    .iss0  (iss[0]),
    .iss1  (iss[1]),
    .slot0 (slot[0]),
    .slot1 (slot[1])
  );

  for (genvar s = 0; s < 2; s++) begin : g_haz
    logic older_wr;
    if (s == 0) begin : g_first
      assign older_wr = 1'b0;
    end else begin : g_second
      assign older_wr = slot[0].vld && slot[0].dst_en;
    end
    issue_hazard u_haz (
      .ins       (slot[s]),
      .busy      (busy_vec),
      .older_wr  (older_wr),
      .older_dst (slot[0].dst),
      .clear     (clear[s])
    );
  end

  assign iss[0] = !flush && slot[0].vld && clear[0];
  assign iss[1] = iss[0] && slot[1].vld && !slot[1].mul && clear[1];

  assign in_ready = !flush && (!slot[0].vld || iss[0]) && (!slot[1].vld || iss[1]);
  assign take     = in_valid && in_ready;

  issue_scoreboard u_sb (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush),
    .wr0_en  (iss[0] && slot[0].dst_en),
    .wr0_idx (slot[0].dst),
    .wr0_lat (slot[0].lat),
    .wr1_en  (iss[1] && slot[1].dst_en),
    .wr1_idx (slot[1].dst),
    .wr1_lat (slot[1].lat),
    .busy    (busy_vec)
  );

  assign p0_issue  = iss[0];
  assign p0_mul    = slot[0].mul;
  assign p0_dst_en = slot[0].dst_en;
  assign p0_dst    = slot[0].dst;
  assign p0_lat    = slot[0].lat;
  assign p1_issue  = iss[1];
  assign p1_dst_en = slot[1].dst_en;
  assign p1_dst    = slot[1].dst;
  assign p1_lat    = slot[1].lat;
endmodule

// File: rtl/issue_checker.sv
module issue_checker
  import issue_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             in_ready,
  input logic             p0_issue,
  input logic             p1_issue,
  input logic             h1_mul,
  input logic [NSRC-1:0]  h0_src_en,
  input logic [SRC_W-1:0] h0_src,
  input logic [NREG-1:0]  busy
);
  function automatic logic reads_pending(input logic [NSRC-1:0] en,
                                         input logic [SRC_W-1:0] src,
                                         input logic [NREG-1:0] pend);
    logic hit;
    hit = 1'b0;
    for (int k = 0; k < NSRC; k++)
      if (en[k] && pend[src[k*REG_W +: REG_W]]) hit = 1'b1;
    return hit;
  endfunction

  assert_pipe1_after_pipe0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    p1_issue |-> p0_issue);

  assert_mul_pipe0_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    p1_issue |-> !h1_mul);

  assert_no_raw_issue_R4: assert property (@(posedge clk) disable iff (!rst_n)
    p0_issue |-> !reads_pending(h0_src_en, h0_src, busy));

  assert_flush_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (!p0_issue && !p1_issue && !in_ready));

  assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (busy == '0));

  assert_reg0_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy[0]);
endmodule

bind pair_issue_stage issue_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .flush     (flush),
  .in_ready  (in_ready),
  .p0_issue  (p0_issue),
  .p1_issue  (p1_issue),
  .h1_mul    (slot[1].mul),
  .h0_src_en (slot[0].src_en),
  .h0_src    (slot[0].src),
  .busy      (busy_vec)
);

// File: tb/pair_issue_stage_test.sv
`timescale 1ns/1ps
module pair_issue_stage_test;
  import issue_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  instr_t b0 = '0, b1 = '0;
  logic p0_issue, p0_mul, p0_dst_en, p1_issue, p1_dst_en;
  logic [REG_W-1:0] p0_dst, p1_dst;
  logic [LAT_W-1:0] p0_lat, p1_lat;

  always #10 clk = ~clk;

  pair_issue_stage uut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid), .in_ready(in_ready),
    .s0_valid(b0.vld), .s0_mul(b0.mul), .s0_lat(b0.lat), .s0_dst_en(b0.dst_en),
    .s0_dst(b0.dst), .s0_src_en(b0.src_en), .s0_src(b0.src),
    .s1_valid(b1.vld), .s1_mul(b1.mul), .s1_lat(b1.lat), .s1_dst_en(b1.dst_en),
    .s1_dst(b1.dst), .s1_src_en(b1.src_en), .s1_src(b1.src),
    .p0_issue(p0_issue), .p0_mul(p0_mul), .p0_dst_en(p0_dst_en), .p0_dst(p0_dst),
    .p0_lat(p0_lat), .p1_issue(p1_issue), .p1_dst_en(p1_dst_en), .p1_dst(p1_dst),
    .p1_lat(p1_lat)
  );

  int nchk = 0, nfail = 0, cyc = 0;
  int last0 [NREG], last1 [NREG], cnt0 [NREG], cnt1 [NREG];
  logic mul0 [NREG];

  initial for (int i = 0; i < NREG; i++) begin
    last0[i] = -100; last1[i] = -100; cnt0[i] = 0; cnt1[i] = 0; mul0[i] = 1'b0;
  end

  // stamp strobes a quarter period after each falling edge
  always begin
    @(negedge clk); #5;
    cyc++;
    if (p0_issue) begin last0[p0_dst] = cyc; cnt0[p0_dst]++; mul0[p0_dst] = p0_mul; end
    if (p1_issue) begin last1[p1_dst] = cyc; cnt1[p1_dst]++; end
  end

  task automatic check_eq(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic instr_t mk(input logic mul, input int lat, input int dst,
                                input logic den, input logic [2:0] sen,
                                input int a, input int b, input int c);
    instr_t t;
    t.vld = 1'b1; t.mul = mul; t.lat = LAT_W'(lat); t.dst_en = den;
    t.dst = REG_W'(dst); t.src_en = sen;
    t.src = {REG_W'(c), REG_W'(b), REG_W'(a)};
    return t;
  endfunction

  // called at a falling edge; returns at the falling edge after transfer
  task automatic push(input instr_t a, input instr_t b);
    b0 = a; b1 = b; in_valid = 1'b1;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    in_valid = 1'b0; b0 = '0; b1 = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  instr_t none = '0;

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("  End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check_eq("R11 in_ready", int'(in_ready), 1);
    check_eq("R11 p0_issue", int'(p0_issue), 0);
    check_eq("R11 p1_issue", int'(p1_issue), 0);
    @(negedge clk);

    // R4 latency sweep, 0 behaves as 1
    for (int L = 0; L < 8; L++) begin
      push(mk(0, L, 1 + (L % 7), 1, 3'b001, 0, 0, 0), none);
      push(mk(0, 1, 8 + (L % 7), 1, 3'b001, 1 + (L % 7), 0, 0), none);
      idle(12);
      check_eq($sformatf("R4 gap lat=%0d", L),
               last0[8 + (L % 7)] - last0[1 + (L % 7)], (L == 0) ? 1 : L);
    end

    // R7 register 0 and disabled destination
    push(mk(0, 7, 0, 1, 3'b000, 0, 0, 0), none);
    push(mk(0, 1, 13, 1, 3'b001, 0, 0, 0), none);
    idle(12);
    check_eq("R7 reg0 gap", last0[13] - last0[0], 1);
    push(mk(0, 7, 5, 0, 3'b000, 0, 0, 0), none);
    push(mk(0, 1, 14, 1, 3'b001, 5, 0, 0), none);
    idle(12);
    check_eq("R7 dst disabled gap", last0[14] - last0[5], 1);

    // R2 independent pair
    push(mk(0, 3, 1, 1, 3'b000, 0, 0, 0), mk(0, 3, 2, 1, 3'b111, 4, 5, 6));
    idle(12);
    check_eq("R2 pair same cycle", last1[2] - last0[1], 0);

    // R5 / R10 sweep over source field position
    for (int k = 0; k < 3; k++) begin
      int s [3];
      s = '{0, 0, 0};
      s[k] = 3;
      push(mk(0, 1, 3, 1, 3'b000, 0, 0, 0), mk(0, 1, 4 + k, 1, 3'b111, s[0], s[1], s[2]));
      idle(12);
      check_eq($sformatf("R5 field %0d moves to pipe0", k), last0[4 + k] - last0[3], 1);
      push(mk(0, 1, 3, 1, 3'b000, 0, 0, 0),
           mk(0, 1, 7 + k, 1, ~(3'b001 << k), s[0], s[1], s[2]));
      idle(12);
      check_eq($sformatf("R10 field %0d disabled", k), last1[7 + k] - last0[3], 0);
    end

    // R5 partner latency 4
    push(mk(0, 4, 3, 1, 3'b000, 0, 0, 0), mk(0, 1, 4, 1, 3'b010, 0, 3, 0));
    idle(12);
    check_eq("R5 partner lat 4", last0[4] - last0[3], 4);

    // R6 multiply in slot 1, and two multiplies
    push(mk(0, 1, 1, 1, 3'b000, 0, 0, 0), mk(1, 3, 2, 1, 3'b000, 0, 0, 0));
    idle(12);
    check_eq("R6 mul moves", last0[2] - last0[1], 1);
    check_eq("R6 mul on pipe0", int'(mul0[2]), 1);
    push(mk(1, 3, 5, 1, 3'b000, 0, 0, 0), mk(1, 3, 6, 1, 3'b000, 0, 0, 0));
    idle(12);
    check_eq("R6 two muls", last0[6] - last0[5], 1);

    // R3 blocked older holds younger, R1 back-pressure
    push(mk(0, 5, 6, 1, 3'b000, 0, 0, 0), none);
    push(mk(0, 1, 7, 1, 3'b001, 6, 0, 0), mk(0, 1, 8, 1, 3'b001, 1, 0, 0));
    #1;
    check_eq("R1 ready low while blocked", int'(in_ready), 0);
    push(mk(0, 1, 9, 1, 3'b000, 0, 0, 0), none);
    idle(12);
    check_eq("R3 older waits lat", last0[7] - last0[6], 5);
    check_eq("R3 pair together", last1[8] - last0[7], 0);
    check_eq("R1 next pair after drain", last0[9] - last0[7], 1);

    // R9 compaction
    base = cnt1[10];
    push(none, mk(0, 1, 10, 1, 3'b000, 0, 0, 0));
    idle(6);
    check_eq("R9 on pipe0", last0[10] - last0[9] > 0 ? 1 : 0, 1);
    check_eq("R9 not on pipe1", cnt1[10] - base, 0);

    // R8 flush drops held pair
    push(mk(0, 7, 11, 1, 3'b000, 0, 0, 0), none);
    base = cnt0[12] + cnt1[13];
    push(mk(0, 1, 12, 1, 3'b001, 11, 0, 0), mk(0, 1, 13, 1, 3'b000, 0, 0, 0));
    flush = 1'b1;
    #1;
    check_eq("R8 ready low", int'(in_ready), 0);
    check_eq("R8 strobe low", int'(p0_issue), 0);
    @(negedge clk);
    flush = 1'b0;
    idle(12);
    check_eq("R8 pair dropped", cnt0[12] + cnt1[13] - base, 0);

    // R8 flush clears scoreboard
    push(mk(0, 7, 11, 1, 3'b000, 0, 0, 0), none);
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    push(mk(0, 1, 15, 1, 3'b001, 11, 0, 0), none);
    idle(12);
    check_eq("R8 marks cleared", last0[15] - last0[11], 3);

    $display("  End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule